// File: doc/BRIEF.md
# Audio Serial Clock Chain

This block derives the two timing signals of a serial audio link, a bit clock and a left/right frame clock, from a master-clock enable strobe. Everything runs in one system clock domain. Each pulse of `mclk_en` stands for one master-clock period, and both outputs are registered levels that advance only on those pulses. Two divider stages are cascaded. The first divides master periods down to the bit clock. The second counts falling bit-clock edges to build the frame clock, so the frame clock is never derived from the master clock directly.

A single `enable` input runs both outputs. When `enable` rises from idle, both outputs start low and the frame begins with its low half. When `enable` drops, the chain finishes the current frame and parks both outputs low at the frame end. A one-cycle `frame_start` strobe marks every rising edge of the frame clock. Frame codes outside the supported set hold the frame clock low and raise a flag.

Top module: `audio_clk_chain`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bclk`, `lrclk`, `frame_start` and `frame_code_err` are all 0 and the chain is idle.
- R2: With `bclk_code` = 0 a bit-clock period is 2 master ticks, and with `bclk_code` = 1 it is 4 master ticks. The duty cycle is 50%, and the first change after a start is a rise after half a period.
- R3: `frame_code` values 0, 1 and 2 give a frame period of 32, 64 and 128 bit-clock periods. The duty cycle is 50% and the low half comes first.
- R4: `lrclk` changes only in the cycle where `bclk` falls from 1 to 0.
- R5: A start from idle (`enable` = 1) leaves `bclk` and `lrclk` low in the first cycle after it and counts master ticks from zero.
- R6: After `enable` drops, both clocks keep running until the end of the current frame, where `lrclk` would fall. There they go low and stay low. An `enable` low pulse that ends before that point does not disturb the output.
- R7: `frame_code` values 3 to 7 hold `lrclk` and `frame_start` at 0 while `bclk` keeps running. `frame_code_err` is 1 from the cycle after such a code is applied. With `enable` low, the chain stops at the next falling `bclk`.
- R8: `frame_start` is high for exactly the one cycle in which `lrclk` goes from 0 to 1, and `bclk` is 0 in that cycle.
- R9: In cycles with `mclk_en` = 0 the clocks do not advance, and while idle, master ticks leave the outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | One pulse per master-clock period |
| enable | input | 1 | Shared run request for both clocks |
| bclk_code | input | 1 | Bit-clock ratio select: 0 gives /2, 1 gives /4 |
| frame_code | input | 3 | Frame ratio select: 0, 1, 2 give /32, /64, /128; 3 to 7 are invalid |
| bclk | output | 1 | Bit clock level |
| lrclk | output | 1 | Left/right frame clock level |
| frame_start | output | 1 | One-cycle strobe on each lrclk rise |
| frame_code_err | output | 1 | Unsupported frame code applied |

## Verification
The bench sweeps every ratio pair with master pulses on every cycle and also on every third cycle, comparing each output each cycle against a closed-form function of the master-tick count.

Several disable cases are covered:
- Dropping `enable` in the high half of a frame.
- Dropping it in the low half, where a design that stops at the frame-clock rise would cut the frame short.
- A short `enable` dip, which a design that stops immediately would turn into a truncated frame.

Every invalid code is applied, so a design that keeps toggling the frame clock, or that waits for a frame boundary that never comes before stopping, is caught. Each frame-clock change is checked to coincide with a falling bit clock, which exposes a frame stage clocked from the master rate.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Width of the frame ratio select field.
  localparam int ACLK_FCODE_W = 3;

  // Counter width for a range 0..n-1, never below one bit.
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/aclk_run_ctrl.sv
module aclk_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic boundary,
  output logic running,
  output logic clear
);

  logic run_q;
  logic start_c;
  logic stop_c;

  // Start from idle at once; stop only at a frame boundary.
  assign start_c = !run_q && enable;
  assign stop_c  = run_q && boundary && !enable;
  assign clear   = start_c || stop_c;
  assign running = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (start_c) begin
      run_q <= 1'b1;
    end else if (stop_c) begin
      run_q <= 1'b0;
    end
  end

  // R6: once running, the chain stays running until a boundary is seen.
  p_no_early_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (run_q && !boundary) |=> run_q);

endmodule

// File: rtl/aclk_bit_stage.sv
module aclk_bit_stage #(
  parameter int BASE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  input  logic code,
  output logic bclk,
  output logic fall_evt
);

  // Half a bit period is at most BASE master ticks.
  localparam int CW = aclk_pkg::cnt_width(BASE);

  logic [CW-1:0] cnt_q;
  logic          bclk_q;
  logic [CW-1:0] lim;
  logic          term;

  always_comb begin
    lim = CW'(((BASE << code) >> 1) - 1);
  end

  // Comparing with >= keeps a code change mid-run from overrunning the counter.
  assign term     = (cnt_q >= lim);
  assign fall_evt = adv && term && bclk_q;
  assign bclk     = bclk_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (adv) begin
      if (term) begin
        cnt_q  <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9: the bit clock holds without a master tick.
  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clear) |=> $stable(bclk_q));

endmodule

// File: rtl/aclk_frame_stage.sv
module aclk_frame_stage #(
  parameter int BASE   = 32,
  parameter int NCODES = 3,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              lrclk,
  output logic              fstart,
  output logic              err,
  output logic              boundary
);

  // The largest half-frame, in bit periods, sets the counter width.
  localparam int HMAX = (BASE << (NCODES - 1)) >> 1;
  localparam int LW   = aclk_pkg::cnt_width(HMAX);

  logic [LW-1:0] bcnt_q;
  logic          lr_q;
  logic          fs_q;
  logic          err_q;
  logic          valid;
  logic [LW-1:0] lim;
  logic          term;

  assign valid = (int'(code) < NCODES);

  always_comb begin
    lim = '0;
    if (valid) begin
      lim = LW'(((BASE << code) >> 1) - 1);
    end
  end

  assign term = (bcnt_q >= lim);
  // A boundary is the end of a frame, or any falling bit-clock edge while the code is invalid.
  assign boundary = step && (!valid || (term && lr_q));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bcnt_q <= '0;
      lr_q   <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      if (!valid) begin
        bcnt_q <= '0;
        lr_q   <= 1'b0;
      end else if (step) begin
        if (term) begin
          bcnt_q <= '0;
          lr_q   <= ~lr_q;
          fs_q   <= ~lr_q;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else begin
      err_q <= !valid;
    end
  end

  assign lrclk  = lr_q;
  assign fstart = fs_q;
  assign err    = err_q;

  // R7: an unsupported code keeps the frame clock low.
  p_err_lr_low_r7: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !lr_q);

endmodule

// File: rtl/audio_clk_chain.sv
module audio_clk_chain #(
  parameter int BCLK_BASE   = 2,
  parameter int FRAME_BASE  = 32,
  parameter int FRAME_CODES = 3,
  parameter int FCODE_W     = aclk_pkg::ACLK_FCODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mclk_en,
  input  logic               enable,
  input  logic               bclk_code,
  input  logic [FCODE_W-1:0] frame_code,
  output logic               bclk,
  output logic               lrclk,
  output logic               frame_start,
  output logic               frame_code_err
);

  logic running;
  logic clear;
  logic boundary;
  logic fall_evt;
  logic adv;
  logic code_ok;

  assign adv     = running && mclk_en;
  assign code_ok = (int'(frame_code) < FRAME_CODES);

  aclk_run_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .boundary (boundary),
    .running  (running),
    .clear    (clear)
  );

  aclk_bit_stage #(.BASE(BCLK_BASE)) u_bit (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .adv      (adv),
    .code     (bclk_code),
    .bclk     (bclk),
    .fall_evt (fall_evt)
  );

  aclk_frame_stage #(
    .BASE   (FRAME_BASE),
    .NCODES (FRAME_CODES),
    .CODE_W (FCODE_W)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .step     (fall_evt),
    .code     (frame_code),
    .lrclk    (lrclk),
    .fstart   (frame_start),
    .err      (frame_code_err),
    .boundary (boundary)
  );

  // R6: with the chain idle, both clocks sit low.
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!bclk && !lrclk));

  // R4: a frame clock change under a valid code coincides with a falling bit clock.
  p_lr_on_bfall_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lrclk) && $past(code_ok)) |-> $fell(bclk));

  // R8: the strobe matches the frame clock rise exactly.
  p_fs_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(lrclk) |-> frame_start);
  p_fs_only_rise_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ($rose(lrclk) && !bclk));

endmodule

// File: tb/audio_clk_chain_test.sv
module audio_clk_chain_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mclk_en = 1'b0;
  logic       enable = 1'b0;
  logic       bclk_code = 1'b0;
  logic [2:0] frame_code = 3'd0;
  logic       bclk;
  logic       lrclk;
  logic       frame_start;
  logic       frame_code_err;

  int n_checks = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  audio_clk_chain uut (
    .clk            (clk),
    .rst            (rst),
    .mclk_en        (mclk_en),
    .enable         (enable),
    .bclk_code      (bclk_code),
    .frame_code     (frame_code),
    .bclk           (bclk),
    .lrclk          (lrclk),
    .frame_start    (frame_start),
    .frame_code_err (frame_code_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One run: start, tick with the given spacing, optional one-cycle enable dip,
  // drop enable once dis_tick master ticks have passed, and follow the chain to idle.
  task automatic run_seq(input bit bc, input logic [2:0] fc, input int gap,
                         input int dis_tick, input int blip_tick);
    int  half, per, hframe, t, cyc, guard;
    bit  valid, stopped, tick, en_edge, blip_done;
    bit  exp_b, exp_l, exp_f, exp_e, prev_b, prev_l;
    string ltag, btag;
    half   = bc ? 2 : 1;
    valid  = (fc < 3);
    hframe = ((2 << bc) * (32 << fc)) / 2;
    per    = valid ? (2 << bc) * (32 << fc) : (2 << bc);
    exp_e  = !valid;
    @(negedge clk);
    bclk_code = bc; frame_code = fc; enable = 1'b1; mclk_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(bclk == 1'b0 && lrclk == 1'b0 && frame_start == 1'b0, "R5", "start levels",
        {bclk, lrclk, frame_start}, 0);
    chk(frame_code_err == exp_e, "R7", "err flag", frame_code_err, exp_e);
    t = 0; cyc = 0; stopped = 0; blip_done = 0; guard = 0;
    prev_b = bclk; prev_l = lrclk;
    while (!stopped && guard < 20000) begin
      guard++;
      tick = ((cyc % gap) == 0);
      cyc++;
      mclk_en = tick;
      if (t >= dis_tick) enable = 1'b0;
      else if (blip_tick >= 0 && t == blip_tick && !blip_done) begin
        enable = 1'b0; blip_done = 1;
      end else enable = 1'b1;
      en_edge = enable;
      @(posedge clk);
      if (tick) t++;
      if (tick && !en_edge && (t % per) == 0) stopped = 1;
      exp_b = stopped ? 1'b0 : bit'((t / half) % 2);
      exp_l = (stopped || !valid) ? 1'b0 : bit'((t / hframe) % 2);
      exp_f = !stopped && exp_l && !prev_l;
      ltag = stopped ? "R6" : (valid ? "R3" : "R7");
      btag = stopped ? "R6" : (tick ? "R2" : "R9");
      @(negedge clk);
      chk(bclk == exp_b, btag, $sformatf("bclk t=%0d", t), bclk, exp_b);
      chk(lrclk == exp_l, ltag, $sformatf("lrclk t=%0d", t), lrclk, exp_l);
      chk(frame_start == exp_f, "R8", $sformatf("frame_start t=%0d", t), frame_start, exp_f);
      chk(frame_code_err == exp_e, "R7", "err flag", frame_code_err, exp_e);
      if (lrclk != prev_l) begin
        chk(prev_b == 1'b1 && bclk == 1'b0, "R4", "lrclk moved without bclk fall",
            {prev_b, bclk}, 2);
      end
      prev_b = bclk; prev_l = lrclk;
    end
    // R6: parked low under further master ticks.
    for (int i = 0; i < 6; i++) begin
      mclk_en = 1'b1; enable = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(bclk == 1'b0 && lrclk == 1'b0 && frame_start == 1'b0, "R6", "parked levels",
          {bclk, lrclk, frame_start}, 0);
    end
    mclk_en = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(bclk == 1'b0 && lrclk == 1'b0 && frame_start == 1'b0 && frame_code_err == 1'b0,
        "R1", "levels in reset", {bclk, lrclk, frame_start, frame_code_err}, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(bclk == 1'b0 && lrclk == 1'b0 && frame_start == 1'b0 && frame_code_err == 1'b0,
        "R1", "levels after reset", {bclk, lrclk, frame_start, frame_code_err}, 0);
    // R9: idle with master ticks and no enable stays low.
    for (int i = 0; i < 8; i++) begin
      mclk_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(bclk == 1'b0 && lrclk == 1'b0, "R9", "idle levels", {bclk, lrclk}, 0);
    end
    mclk_en = 1'b0;
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 3; f++) begin
        int per;
        per = (2 << b) * (32 << f);
        // Drop enable in the high half of the second frame.
        run_seq(bit'(b), 3'(f), 1, 2 * per - per / 4, -1);
        // Sparse ticks, an enable dip, then a drop in the low half of the second frame.
        run_seq(bit'(b), 3'(f), 3, per + 3, per / 4);
      end
    end
    for (int b = 0; b < 2; b++) begin
      for (int f = 3; f < 8; f++) begin
        run_seq(bit'(b), 3'(f), (f % 2) + 1, 3 * (2 << b) + 1, -1);
      end
    end
    // Back to a valid code: the flag clears and the frame clock resumes.
    run_seq(1'b0, 3'd0, 1, 40, -1);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule